// File: doc/BRIEF.md
# Dual-Port Register File with Wired-AND Depth Expansion

The block stores small words in an array of register files. Each file holds four 4-bit words. Each file has its own write decoder and its own read decoder, so one word can be written while another is read in the same cycle. Writes take effect on the rising clock edge when the active-low write enable is asserted. Reads are combinational from the stored array. A file whose read side is disabled drives all ones, like an open-collector output that is not pulling low.

The top module puts `BANKS = 2**BANK_BITS` files side by side on a common data path. The upper address bits pick one file for writing and one file for reading. The read outputs of all files are combined by bitwise AND, as a wired-AND bus would combine them. Only the selected file drives real data, and every other file contributes ones. Setting `BANK_BITS` grows the word count. Placing several tops next to each other widens the word.

A synchronous reset clears every word to zero.

Top module: `rf_bank_array`

## Requirements
- R1: With defaults, each file holds 4 words of 4 bits. The 4-bit address uses bits [3:2] to select one of 4 files and bits [1:0] to select the word inside that file, giving 16 words in total.
- R2: At a rising clock edge with `wr_en_n` = 0, the word at `wr_addr` takes the value of `wr_data`, stored in true form (a 1 written reads back as a 1).
- R3: At an edge with `wr_en_n` = 1, no stored word changes, whatever `wr_data` and `wr_addr` hold.
- R4: While `rd_en_n` = 1, `rd_data` is all ones (4'hF).
- R5: While `rd_en_n` = 0, `rd_data` shows the word stored at `rd_addr` in the same cycle, with no clock edge needed.
- R6: A write to one address and a read from a different address in the same cycle both complete. The read shows the stored value of its own word.
- R7: If the read address equals the write address in a write cycle, the read shows the old word before the edge and the new word after it.
- R8: Reading does not change the stored word: repeated reads return the same value.
- R9: While `rst` = 1 at an edge, all words are cleared to 0, and a write in that same cycle is discarded.
- R10: `rd_data` is the bitwise AND of every file's read output. Files not selected by `rd_addr[3:2]` contribute all ones.
- R11: A write changes only the one file selected by `wr_addr[3:2]`. The same word index in the other files keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all words |
| wr_addr | input | 4 | Write address: [3:2] file, [1:0] word |
| wr_data | input | 4 | Data word to store |
| wr_en_n | input | 1 | Write enable, active low |
| rd_addr | input | 4 | Read address: [3:2] file, [1:0] word |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 4 | Read word, all ones while reading is disabled |

## Verification
The bench builds the top with its default values: 4-bit words, 4 words per file and `BANK_BITS` = 2, which gives four files joined through the wired-AND output. With four files in place, a write to one file can be checked against the same word index in a neighbouring file. The bench can also confirm that the unselected files never pull a bit of the combined output low. Because the whole 16-word space is small, the bench sweeps every address after each reset.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // One-hot decode of a binary index into N select lines
  function automatic logic [63:0] onehot_of(input int unsigned idx, input int unsigned n);
    logic [63:0] v;
    v = '0;
    for (int unsigned i = 0; i < n; i++) v[i] = (idx == i);
    return v;
  endfunction

  // An enable is active only when the global enable is low and the bank matches
  function automatic logic bank_enable_n(input logic en_n, input int unsigned sel,
                                         input int unsigned mine);
    return en_n | (sel != mine);
  endfunction
endpackage

// File: rtl/rf_wr_decoder.sv
module rf_wr_decoder #(
  parameter int WORDS = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [AW-1:0]    addr,
  input  logic             en_n,
  output logic [WORDS-1:0] sel
);
  logic [63:0] dec;
  always_comb begin
    dec = rf_pkg::onehot_of(int'(addr), WORDS);
    sel = en_n ? '0 : dec[WORDS-1:0];
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int WORD_W = 4,
  parameter int WORDS  = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [WORDS-1:0][WORD_W-1:0] words,
  input  logic [AW-1:0]                addr,
  input  logic                         en_n,
  output logic [WORD_W-1:0]            dout
);
  always_comb begin
    dout = '1;
    if (!en_n) dout = words[addr];
  end
endmodule

// File: rtl/rf_core.sv
module rf_core #(
  parameter int WORD_W = 4,
  parameter int WORDS  = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en_n,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_en_n,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORDS-1:0]             wr_sel;
  logic [WORDS-1:0][WORD_W-1:0] mem_q;

  rf_wr_decoder #(.WORDS(WORDS)) wdec_i (
    .addr(wr_addr), .en_n(wr_en_n), .sel(wr_sel)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)            mem_q[w] <= '0;
      else if (wr_sel[w]) mem_q[w] <= wr_data;
    end
  end

  rf_rd_port #(.WORD_W(WORD_W), .WORDS(WORDS)) rport_i (
    .words(mem_q), .addr(rd_addr), .en_n(rd_en_n), .dout(rd_data)
  );
endmodule

// File: rtl/rf_bank_array.sv
module rf_bank_array #(
  parameter int WORD_W    = 4,
  parameter int WORDS     = 4,
  parameter int BANK_BITS = 2,
  localparam int BANKS  = 1 << BANK_BITS,
  localparam int LAW    = $clog2(WORDS),
  localparam int ADDR_W = LAW + BANK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en_n,
  output logic [WORD_W-1:0] rd_data
);
  // Named per-bank events, visible to the checker
  logic [BANKS-1:0]             bank_wr_en_n;
  logic [BANKS-1:0]             bank_rd_en_n;
  logic [BANKS-1:0][WORD_W-1:0] bank_rd_data;
  logic [BANK_BITS-1:0]         wr_bank, rd_bank;

  assign wr_bank = wr_addr[ADDR_W-1 -: BANK_BITS];
  assign rd_bank = rd_addr[ADDR_W-1 -: BANK_BITS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_wr_en_n[b] = rf_pkg::bank_enable_n(wr_en_n, int'(wr_bank), b);
    assign bank_rd_en_n[b] = rf_pkg::bank_enable_n(rd_en_n, int'(rd_bank), b);
    rf_core #(.WORD_W(WORD_W), .WORDS(WORDS)) core_i (
      .clk(clk), .rst(rst),
      .wr_addr(wr_addr[LAW-1:0]), .wr_data(wr_data), .wr_en_n(bank_wr_en_n[b]),
      .rd_addr(rd_addr[LAW-1:0]), .rd_en_n(bank_rd_en_n[b]),
      .rd_data(bank_rd_data[b])
    );
  end

  // Wired-AND of all bank outputs
  always_comb begin
    rd_data = '1;
    for (int b = 0; b < BANKS; b++) rd_data &= bank_rd_data[b];
  end
endmodule

// File: rtl/rf_bank_array_chk.sv
module rf_bank_array_chk #(
  parameter int WORD_W = 4,
  parameter int BANKS  = 4,
  parameter int ADDR_W = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic [WORD_W-1:0]            wr_data,
  input logic                         wr_en_n,
  input logic [ADDR_W-1:0]            rd_addr,
  input logic                         rd_en_n,
  input logic [WORD_W-1:0]            rd_data,
  input logic [BANKS-1:0]             bank_wr_en_n,
  input logic [BANKS-1:0]             bank_rd_en_n,
  input logic [BANKS-1:0][WORD_W-1:0] bank_rd_data
);
  AST_IDLE_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |-> rd_data == '1);  // R4

  AST_ONE_BANK_WRITES: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bank_wr_en_n));  // R11

  AST_ONE_BANK_READS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bank_rd_en_n));  // R10

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en_n) && !rd_en_n && $stable(rd_en_n) && $stable(rd_addr))
      |-> $stable(rd_data));  // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en_n) && !rd_en_n && rd_addr == $past(wr_addr))
      |-> rd_data == $past(wr_data));  // R7

  AST_UNSELECTED_ONES: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_rd_en_n) == BANKS |-> bank_rd_data == '1);  // R10
endmodule

bind rf_bank_array rf_bank_array_chk #(
  .WORD_W(WORD_W), .BANKS(BANKS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en_n(wr_en_n),
  .rd_addr(rd_addr), .rd_en_n(rd_en_n), .rd_data(rd_data),
  .bank_wr_en_n(bank_wr_en_n), .bank_rd_en_n(bank_rd_en_n), .bank_rd_data(bank_rd_data)
);

// File: tb/rf_bank_array_tb_top.sv
module rf_bank_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic       wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [3:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_bank_array dut_i (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en_n(wr_en_n),
    .rd_addr(rd_addr), .rd_en_n(rd_en_n), .rd_data(rd_data)
  );

  // {we_n, wa, wd, re_n, ra, expected read before the edge}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 4'h0, 4'h5, 1'b1, 4'h0, 4'hF},  // R4 disabled read, write addr 0
    {1'b0, 4'h5, 4'hA, 1'b0, 4'h0, 4'h5},  // R2 R5 R6
    {1'b0, 4'hF, 4'h3, 1'b0, 4'h5, 4'hA},  // R6
    {1'b1, 4'h0, 4'hF, 1'b0, 4'hF, 4'h3},  // R1 top word
    {1'b1, 4'h0, 4'hF, 1'b0, 4'h0, 4'h5},  // R3 inhibited write
    {1'b0, 4'hA, 4'h9, 1'b0, 4'hA, 4'h0},  // R7 old value
    {1'b1, 4'h0, 4'h0, 1'b0, 4'hA, 4'h9},  // R7 new value
    {1'b1, 4'h0, 4'h0, 1'b0, 4'hA, 4'h9},  // R8 nondestructive
    {1'b0, 4'h1, 4'hC, 1'b0, 4'h5, 4'hA},  // R11 write file 0 word 1
    {1'b1, 4'h0, 4'h0, 1'b0, 4'h1, 4'hC},  // R2
    {1'b1, 4'h0, 4'h0, 1'b0, 4'h5, 4'hA},  // R11 file 1 word 1 kept
    {1'b1, 4'h0, 4'h0, 1'b0, 4'h9, 4'h0},  // R10 R11 file 2 word 1
    {1'b1, 4'h0, 4'h0, 1'b1, 4'h5, 4'hF}   // R10 unselected ones
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic sweep_zero(input string req);
    for (int a = 0; a < 16; a++) begin
      rd_en_n = 1'b0; rd_addr = 4'(a);
      #1 check(rd_data, 4'h0, req);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    sweep_zero("R9 reset state");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {wr_en_n, wr_addr, wr_data, rd_en_n, rd_addr} = VEC[i][17:4];
      #1 check(rd_data, VEC[i][3:0], $sformatf("R5 vector %0d", i));
    end

    // Reset beats a simultaneous write
    @(negedge clk);
    wr_en_n = 1'b1; rd_en_n = 1'b0; rd_addr = 4'h5;
    #1 check(rd_data, 4'hA, "R8 before reset");
    @(negedge clk);
    rst = 1'b1; wr_en_n = 1'b0; wr_addr = 4'h6; wr_data = 4'hE;
    @(negedge clk);
    rst = 1'b0; wr_en_n = 1'b1;
    sweep_zero("R9 cleared, write dropped");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule